// File: doc/BRIEF.md
# Floating-Point Pack and Round Unit

This unit turns an unpacked floating-point value into an IEEE-754 bit pattern in either single or double precision. The unpacked value has a three-bit class code, a sign, a signed unbiased exponent and a 64-bit fraction. For a normal number, the fraction's implicit one sits at bit 60: 52 fraction bits plus 8 guard bits, so the alignment is always the double-precision one. The output is registered with a one-cycle latency, and a valid pulse travels alongside the data.

For normal numbers the unit rounds to nearest, ties to even, using the guard bits. When rounding carries out, the unit renormalizes the fraction. An exponent too large for the format gives a signed infinity. An exponent too small gives a subnormal result, which is truncated rather than rounded. Zero, infinity and NaN classes map directly to their encodings. A NaN always leaves the unit negative and keeps the low fraction bits of its payload.

Top module: `fpk_pack_round`

## Requirements
- R1: `out_valid` equals `in_valid` one clock later. While `rst_n` is low, `out_valid` and `out_bits` are 0.
- R2: On a cycle with `in_valid` low, `out_bits` keeps its previous value.
- R3: Class code 3 is a number. In double mode (`in_dbl`=1) the exponent field is exp+1023 at bits 62:52, and the fraction is `in_frac` bits 59:8 after rounding. In single mode the exponent field is exp+127 at bits 30:23, and the fraction is taken after `in_frac` is shifted right by 30. Single mode has 7 guard bits and double mode has 8.
- R4: Tie case: the guard field equals exactly its top bit (0x80 in double, 0x40 in single). In that case the unit adds 0x80 (double) or 0x40 (single) only when the lowest kept fraction bit is 1. Otherwise the value is left as it is.
- R5: In every case other than the tie, the unit adds 0x7F (double) or 0x3F (single) to the aligned fraction and then drops the guard bits.
- R6: If the rounded fraction reaches the bit above the implicit one, the unit shifts it right by one and raises the exponent by one.
- R7: A number whose exponent is above the bias becomes infinity: exponent field all ones, fraction 0, sign kept.
- R8: A number whose exponent is below 1−bias gets exponent field 0. Its aligned fraction is shifted right by (1−bias−exp) and then by the guard count, with no rounding.
- R9: In the subnormal case, a shift amount (1−bias−exp) larger than 64 minus the guard count gives a fraction of 0.
- R10: Class code 2 (zero) gives exponent 0 and fraction 0. Class code 4 (infinity) gives exponent all ones and fraction 0. Both keep the input sign.
- R11: Class codes 0 and 1 (the two NaNs) force the sign to 1 and the exponent to all ones. The fraction field is the low 52 (double) or 23 (single) bits of `in_frac`, unshifted.
- R12: In single mode `out_bits[63:32]` is 0.
- R13: Class codes 5 to 7 are treated as NaN, as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value present |
| in_dbl | input | 1 | 1 = double precision, 0 = single |
| in_cls | input | 3 | Class: 0 signaling NaN, 1 quiet NaN, 2 zero, 3 number, 4 infinity |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | 16 | Signed unbiased exponent |
| in_frac | input | 64 | Fraction with the implicit one at bit 60 |
| out_valid | output | 1 | Result present |
| out_bits | output | 64 | Packed IEEE-754 result |

## Verification
Errors in the guard-field decode or in the carry detection corrupt only the least significant fraction bit, or the exponent by one, in the cycle after the input. For that reason every result is compared in full against the reference at the next sample point. A wrong result register enable shows up as a changed `out_bits` on an idle cycle. A wrong boundary in the underflow or overflow compare moves the result across a class boundary, so values at exactly the bias, at 1−bias and at the flush threshold are applied directly.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  localparam int DATA_W   = 64;
  localparam int EXP_IN_W = 16;
  localparam int NFMT     = 2;

  localparam int DP_EXP   = 11;
  localparam int DP_FRAC  = 52;
  localparam int DP_GUARD = 8;
  localparam int SP_EXP   = 8;
  localparam int SP_FRAC  = 23;
  localparam int SP_GUARD = 7;

  typedef enum logic [2:0] {
    CLS_SNAN = 3'd0,
    CLS_QNAN = 3'd1,
    CLS_ZERO = 3'd2,
    CLS_NUM  = 3'd3,
    CLS_INF  = 3'd4
  } fpk_cls_e;

  function automatic int fmt_exp_bits(input int dbl);
    return (dbl != 0) ? DP_EXP : SP_EXP;
  endfunction

  function automatic int fmt_frac_bits(input int dbl);
    return (dbl != 0) ? DP_FRAC : SP_FRAC;
  endfunction

  function automatic int fmt_guard(input int dbl);
    return (dbl != 0) ? DP_GUARD : SP_GUARD;
  endfunction

  // right shift that moves the double-aligned fraction into this format
  function automatic int fmt_align(input int dbl);
    return (DP_FRAC + DP_GUARD) - (fmt_frac_bits(dbl) + fmt_guard(dbl));
  endfunction
endpackage

// File: rtl/fpk_rounder.sv
module fpk_rounder #(
  parameter int DATA_W    = 64,
  parameter int FRAC_BITS = 52,
  parameter int EXP_BITS  = 11,
  parameter int GUARD     = 8
) (
  input  logic [DATA_W-1:0]    frac_i,
  input  logic [EXP_BITS-1:0]  exp_i,
  output logic [FRAC_BITS-1:0] frac_o,
  output logic [EXP_BITS-1:0]  exp_o
);
  localparam int          TOP_POS = FRAC_BITS + 1 + GUARD;
  localparam logic [GUARD-1:0] HALF  = GUARD'(1) << (GUARD - 1);
  localparam logic [GUARD-1:0] BELOW = HALF - GUARD'(1);

  logic [GUARD-1:0]  addend;
  logic              tie;
  logic [DATA_W:0]   sum;
  logic              carry;
  logic [DATA_W:0]   norm;

  always_comb begin
    tie = (frac_i[GUARD-1:0] == HALF);
    if (tie) begin
      addend = frac_i[GUARD] ? HALF : '0;
    end else begin
      addend = BELOW;
    end
    sum   = {1'b0, frac_i} + {{(DATA_W + 1 - GUARD){1'b0}}, addend};
    carry = |(sum >> TOP_POS);
    norm  = carry ? (sum >> 1) : sum;
    frac_o = FRAC_BITS'(norm >> GUARD);
    exp_o  = exp_i + EXP_BITS'(carry);
  end
endmodule

// File: rtl/fpk_denorm.sv
module fpk_denorm #(
  parameter int DATA_W    = 64,
  parameter int FRAC_BITS = 52,
  parameter int GUARD     = 8
) (
  input  logic [DATA_W-1:0]    frac_i,
  input  logic [31:0]          deficit_i,
  output logic [FRAC_BITS-1:0] frac_o
);
  localparam int LIMIT = DATA_W - GUARD;

  logic [DATA_W-1:0] shifted;

  always_comb begin
    if (deficit_i > 32'(LIMIT)) begin
      shifted = '0;
    end else begin
      shifted = (frac_i >> deficit_i) >> GUARD;
    end
    frac_o = FRAC_BITS'(shifted);
  end
endmodule

// File: rtl/fpk_lane.sv
module fpk_lane
  import fpk_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int EXP_IN_W  = 16,
  parameter int EXP_BITS  = 11,
  parameter int FRAC_BITS = 52,
  parameter int GUARD     = 8,
  parameter int ALIGN     = 0
) (
  input  logic [2:0]                 cls_i,
  input  logic                       sign_i,
  input  logic signed [EXP_IN_W-1:0] exp_i,
  input  logic [DATA_W-1:0]          frac_i,
  output logic [DATA_W-1:0]          bits_o
);
  localparam int BIAS     = (1 << (EXP_BITS - 1)) - 1;
  localparam int SIGN_POS = EXP_BITS + FRAC_BITS;
  localparam logic [EXP_BITS-1:0] EXP_ONES = '1;

  logic [DATA_W-1:0]    aligned;
  logic signed [31:0]   e_w;
  logic [31:0]          deficit;
  logic [EXP_BITS-1:0]  biased;
  logic [FRAC_BITS-1:0] rnd_frac;
  logic [EXP_BITS-1:0]  rnd_exp;
  logic [FRAC_BITS-1:0] sub_frac;

  logic                 f_sign;
  logic [EXP_BITS-1:0]  f_exp;
  logic [FRAC_BITS-1:0] f_frac;

  assign aligned = frac_i >> ALIGN;
  assign e_w     = {{(32 - EXP_IN_W){exp_i[EXP_IN_W-1]}}, exp_i};
  assign deficit = 32'(32'sd1 - 32'(BIAS) - e_w);
  assign biased  = EXP_BITS'(e_w + 32'(BIAS));

  fpk_rounder #(
    .DATA_W   (DATA_W),
    .FRAC_BITS(FRAC_BITS),
    .EXP_BITS (EXP_BITS),
    .GUARD    (GUARD)
  ) u_rounder (
    .frac_i(aligned),
    .exp_i (biased),
    .frac_o(rnd_frac),
    .exp_o (rnd_exp)
  );

  fpk_denorm #(
    .DATA_W   (DATA_W),
    .FRAC_BITS(FRAC_BITS),
    .GUARD    (GUARD)
  ) u_denorm (
    .frac_i   (aligned),
    .deficit_i(deficit),
    .frac_o   (sub_frac)
  );

  always_comb begin
    f_sign = sign_i;
    f_exp  = '0;
    f_frac = '0;
    case (cls_i)
      CLS_ZERO: begin
        f_exp  = '0;
        f_frac = '0;
      end
      CLS_INF: begin
        f_exp  = EXP_ONES;
        f_frac = '0;
      end
      CLS_NUM: begin
        if (e_w < (32'sd1 - 32'(BIAS))) begin
          f_exp  = '0;
          f_frac = sub_frac;
        end else if (e_w > 32'(BIAS)) begin
          f_exp  = EXP_ONES;
          f_frac = '0;
        end else begin
          f_exp  = rnd_exp;
          f_frac = rnd_frac;
        end
      end
      default: begin
        f_sign = 1'b1;
        f_exp  = EXP_ONES;
        f_frac = frac_i[FRAC_BITS-1:0];
      end
    endcase
    bits_o = '0;
    bits_o[SIGN_POS]              = f_sign;
    bits_o[FRAC_BITS +: EXP_BITS] = f_exp;
    bits_o[FRAC_BITS-1:0]         = f_frac;
  end
endmodule

// File: rtl/fpk_pack_round.sv
module fpk_pack_round
  import fpk_pkg::*;
#(
  parameter int DW = fpk_pkg::DATA_W,
  parameter int EW = fpk_pkg::EXP_IN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_dbl,
  input  logic [2:0]           in_cls,
  input  logic                 in_sign,
  input  logic signed [EW-1:0] in_exp,
  input  logic [DW-1:0]        in_frac,
  output logic                 out_valid,
  output logic [DW-1:0]        out_bits
);
  logic [DW-1:0] lane_bits [NFMT];

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    fpk_lane #(
      .DATA_W   (DW),
      .EXP_IN_W (EW),
      .EXP_BITS (fmt_exp_bits(g)),
      .FRAC_BITS(fmt_frac_bits(g)),
      .GUARD    (fmt_guard(g)),
      .ALIGN    (fmt_align(g))
    ) u_lane (
      .cls_i (in_cls),
      .sign_i(in_sign),
      .exp_i (in_exp),
      .frac_i(in_frac),
      .bits_o(lane_bits[g])
    );
  end

  logic          valid_d, valid_q;
  logic [DW-1:0] bits_d,  bits_q;

  always_comb begin
    valid_d = in_valid;
    bits_d  = bits_q;
    if (in_valid) begin
      bits_d = in_dbl ? lane_bits[1] : lane_bits[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bits_q  <= '0;
    end else begin
      valid_q <= valid_d;
      bits_q  <= bits_d;
    end
  end

  assign out_valid = valid_q;
  assign out_bits  = bits_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_bits)); // R2
  AST_SINGLE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_dbl |=> out_bits[63:32] == 32'h0); // R12
  AST_NAN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_dbl && (in_cls == CLS_SNAN || in_cls == CLS_QNAN)
      |=> out_bits[63:52] == 12'hFFF); // R11
  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_dbl && in_cls == CLS_NUM && in_exp > 16'sd1023
      |=> out_bits[62:0] == {11'h7FF, 52'h0}); // R7
  AST_ZERO_CLS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_dbl && in_cls == CLS_ZERO
      |=> out_bits[62:0] == 63'h0); // R10
endmodule

// File: tb/fpk_pack_round_bench.sv
`timescale 1ns/1ps
module fpk_pack_round_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_dbl;
  logic [2:0]  in_cls;
  logic        in_sign;
  logic signed [15:0] in_exp;
  logic [63:0] in_frac;
  logic        out_valid;
  logic [63:0] out_bits;

  int checks;
  int failures;
  bit done;

  fpk_pack_round u_fpk_pack_round (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
    .in_cls(in_cls), .in_sign(in_sign), .in_exp(in_exp), .in_frac(in_frac),
    .out_valid(out_valid), .out_bits(out_bits)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference taken from the requirements
  function automatic logic [63:0] model(input logic [2:0] c, input logic s,
                                        input int e, input logic [63:0] f,
                                        input logic d);
    int eb   = d ? 11 : 8;
    int fb   = d ? 52 : 23;
    int g    = d ? 8 : 7;
    int bias = (1 << (eb - 1)) - 1;
    longint unsigned emax = (64'd1 << eb) - 1;
    longint unsigned fs, ex, fr, half;
    longint unsigned sg;
    int sh;
    sg = s; ex = 0; fr = 0;
    fs = d ? f : (f >> 30);
    half = 64'd1 << (g - 1);
    case (c)
      3'd2: begin ex = 0; fr = 0; end
      3'd4: begin ex = emax; fr = 0; end
      3'd3: begin
        if (e < 1 - bias) begin
          sh = 1 - bias - e;
          ex = 0;
          if (sh > 64 - g) fr = 0;
          else fr = (fs >> sh) >> g;
        end else if (e > bias) begin
          ex = emax; fr = 0;
        end else begin
          ex = longint'(e + bias);
          if ((fs % (64'd1 << g)) == half) begin
            if (((fs >> g) & 1) == 1) fs = fs + half;
          end else begin
            fs = fs + half - 1;
          end
          if (fs >= (64'd1 << (fb + 1 + g))) begin
            fs = fs >> 1;
            ex = ex + 1;
          end
          fr = fs >> g;
        end
      end
      default: begin sg = 1; ex = emax; fr = f; end
    endcase
    fr = fr & ((64'd1 << fb) - 1);
    ex = ex & emax;
    return (sg << (eb + fb)) | (ex << fb) | fr;
  endfunction

  logic        exp_v;
  logic [63:0] exp_bits;
  string       cur_tag, exp_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v    <= 1'b0;
      exp_bits <= '0;
      exp_tag  <= "R1 reset";
    end else begin
      exp_v <= in_valid;
      if (in_valid) begin
        exp_bits <= model(in_cls, in_sign, int'(in_exp), in_frac, in_dbl);
        exp_tag  <= cur_tag;
      end else begin
        exp_tag  <= "R2 idle hold";
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== exp_v) begin
        failures++;
        $display("FAIL R1 %s: out_valid=%0b expected=%0b", exp_tag, out_valid, exp_v);
      end
      checks++;
      if (out_bits !== exp_bits) begin
        failures++;
        $display("FAIL %s: out_bits=%h expected=%h", exp_tag, out_bits, exp_bits);
      end
    end
  end

  task automatic put(input string tag, input logic [2:0] c, input logic s,
                     input int e, input logic [63:0] f, input logic d);
    @(negedge clk);
    cur_tag  = tag;
    in_valid = 1'b1;
    in_cls   = c; in_sign = s; in_exp = 16'(e); in_frac = f; in_dbl = d;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_cls   = 3'($urandom); in_sign = 1'($urandom);
    in_exp   = 16'($urandom); in_frac = {$urandom, $urandom}; in_dbl = 1'($urandom);
  endtask

  task automatic expect_now(input string tag, input logic [63:0] want);
    @(negedge clk);
    #1;
    checks++;
    if (out_bits !== want) begin
      failures++;
      $display("FAIL %s: out_bits=%h expected=%h", tag, out_bits, want);
    end
  endtask

  localparam logic [63:0] ONE = 64'd1 << 60;

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_dbl = 1'b0; in_cls = 3'd0;
    in_sign = 1'b0; in_exp = '0; in_frac = '0; cur_tag = "";
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_bits !== 64'h0) begin
      failures++;
      $display("FAIL R1 reset: valid=%0b bits=%h expected 0 0", out_valid, out_bits);
    end
    rst_n = 1'b1;

    // directed vectors, each with a known encoding
    put("R3 double 1.0", 3'd3, 0, 0, ONE, 1);
    expect_now("R3 double 1.0", 64'h3FF0000000000000);
    put("R3 single 1.0", 3'd3, 0, 0, ONE, 0);
    expect_now("R3 single 1.0", 64'h000000003F800000);
    put("R4 tie even kept", 3'd3, 0, 0, ONE | 64'h80, 1);
    expect_now("R4 tie even kept", 64'h3FF0000000000000);
    put("R4 tie odd up", 3'd3, 0, 0, ONE | 64'h180, 1);
    expect_now("R4 tie odd up", 64'h3FF0000000000002);
    put("R4 single tie odd", 3'd3, 0, 0, ONE | (64'hC0 << 30), 0);
    expect_now("R4 single tie odd", 64'h000000003F800002);
    put("R5 above half", 3'd3, 0, 0, ONE | 64'h81, 1);
    expect_now("R5 above half", 64'h3FF0000000000001);
    put("R5 below half", 3'd3, 1, 0, ONE | 64'h7F, 1);
    expect_now("R5 below half", 64'hBFF0000000000000);
    put("R6 carry renorm", 3'd3, 0, 0, (64'd1 << 61) - 1, 1);
    expect_now("R6 carry renorm", 64'h4000000000000000);
    put("R6 carry into inf", 3'd3, 0, 1023, (64'd1 << 61) - 1, 1);
    expect_now("R6 carry into inf", 64'h7FF0000000000000);
    put("R7 overflow", 3'd3, 1, 1024, ONE, 1);
    expect_now("R7 overflow", 64'hFFF0000000000000);
    put("R7 single overflow", 3'd3, 0, 128, ONE, 0);
    expect_now("R7 single overflow", 64'h000000007F800000);
    put("R8 double subnormal", 3'd3, 0, -1023, ONE | 64'hFF, 1);
    expect_now("R8 double subnormal", 64'h0008000000000000);
    put("R8 single subnormal", 3'd3, 1, -127, ONE, 0);
    expect_now("R8 single subnormal", 64'h0000000080400000);
    put("R9 at limit", 3'd3, 0, -1022 - 56, 64'h8000000000000000, 1);
    expect_now("R9 at limit", 64'h0000000000000000);
    put("R9 past limit", 3'd3, 0, -1022 - 57, 64'hFFFFFFFFFFFFFFFF, 1);
    expect_now("R9 past limit", 64'h0000000000000000);
    put("R10 neg zero", 3'd2, 1, 5, ONE, 1);
    expect_now("R10 neg zero", 64'h8000000000000000);
    put("R10 single inf", 3'd4, 0, 0, ONE, 0);
    expect_now("R10 single inf", 64'h000000007F800000);
    put("R11 double nan", 3'd0, 0, 0, 64'h123, 1);
    expect_now("R11 double nan", 64'hFFF0000000000123);
    put("R11 single nan", 3'd1, 0, 0, 64'hFFFF_FFFF_FF80_0123, 0);
    expect_now("R11 single nan", 64'h00000000FF800123);
    put("R13 code 7", 3'd7, 0, 0, 64'h5, 1);
    expect_now("R13 code 7", 64'hFFF0000000000005);

    // idle cycles with noisy inputs must leave the result alone
    idle();
    expect_now("R2 idle hold", 64'hFFF0000000000005);

    // mixed stream compared against the reference every clock
    for (int i = 0; i < 600; i++) begin
      logic d;
      int e;
      d = 1'($urandom);
      e = d ? (int'($urandom % 2200) - 1100) : (int'($urandom % 320) - 160);
      if ($urandom % 4 == 0) idle();
      else put((d ? "R3 R12 random double" : "R12 random single"),
               ($urandom % 5 == 0) ? 3'($urandom) : 3'd3,
               1'($urandom), e, {3'b001, 29'($urandom), $urandom}, d);
    end
    idle();
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not finish expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule